// File: doc/BRIEF.md
# Atomic Wide-Register Byte Bridge

This block sits between an 8-bit load/store bus and a set of peripheral registers that are two or more bytes wide. It lets software move a wide value one byte at a time without tearing it. When software reads the least significant byte of a wide register, it gets the live value of that byte. In the same cycle the block copies the remaining bytes into a shadow. Later reads of those bytes return the copy, so a multi-byte read sees one consistent moment. Writes work the other way round. Bytes below the top one are parked in a holding buffer. A write to the top byte then releases the whole value to the peripheral at once, as a one-cycle update strobe.

The same address window also holds a 16-bit stack pointer, split into a low and a high byte. Writing its low byte raises an interrupt-inhibit signal to the core for a fixed number of cycles. This gives the program time to write the high byte before any interrupt can use a half-updated pointer. One shadow and one holding buffer serve every wide register.

Address map: wide register `i`, byte `j` sits at address `i * 2^BW + j`, where `BW = clog2(BYTES)`. The stack-pointer low byte sits at `NUM_REGS * 2^BW`, and its high byte at the next address.

Top module: `wide_reg_bridge`

## Requirements
- R1: A read of byte 0 of a mapped wide register puts that register's live byte 0 on `rdData` in the same cycle as `rdEn`.
- R2: A byte-0 read copies live bytes 1 to BYTES-1 of that register into the shared shadow. Later reads of bytes 1 to BYTES-1 of any wide register return the shadow, not the live value, even if the live value has since changed.
- R3: Reading byte 1 or higher with no byte-0 read before it returns the last shadow contents. After reset these contents are zero.
- R4: A write to any byte below the top byte stores the data in the shared holding buffer at that byte position. `updValid` stays low in the next cycle.
- R5: A write to the top byte (byte BYTES-1) of register `i` makes `updValid` high for exactly the next cycle. In that cycle `updIdx` equals `i` and `updValue` equals {write data, buffer bytes BYTES-2 down to 0}.
- R6: The holding buffer is shared. Bytes written through one register's address are used by a top-byte commit to a different register.
- R7: A write to the stack-pointer low byte updates `spValue[7:0]` in the next cycle. It also holds `intInhibit` high for exactly INHIBIT_CYCLES cycles (default 4), starting in the cycle after the write.
- R8: A stack-pointer low-byte write while `intInhibit` is already high restarts the full INHIBIT_CYCLES window.
- R9: A write to the stack-pointer high byte updates `spValue[15:8]` in the next cycle and does not raise `intInhibit`. Reads of either stack-pointer byte return the current stack-pointer byte.
- R10: After reset, the shadow and the buffer hold zero, `intInhibit` and `updValid` are low, and `spValue` equals SP_RESET.
- R11: A read of an unmapped address returns 0, and `rdData` is 0 whenever `rdEn` is low. A write to an unmapped address changes nothing: no buffer byte, no stack-pointer byte and no update strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Byte address |
| rdEn | input | 1 | Read strobe |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write byte |
| liveRegs | input | NUM_REGS*BYTES*8 | Live peripheral register values, register 0 in the low bits |
| rdData | output | 8 | Read byte, combinational |
| updValid | output | 1 | One-cycle atomic update strobe |
| updIdx | output | IDX_W | Index of the register being updated |
| updValue | output | BYTES*8 | Full assembled register value |
| spValue | output | 16 | Stack pointer |
| intInhibit | output | 1 | Interrupt inhibit to the core |

## Verification
The bench builds the block with four registers of three bytes each and a four-cycle inhibit window. Three bytes per register means each register has two upper bytes that are snapshotted together and two lower bytes that are buffered together, so byte-position mistakes in the shadow and the buffer become visible. The unused fourth byte slot in each register's address range gives unmapped addresses inside the register window as well as above the stack-pointer bytes. Random mixes of reads, writes and stack-pointer accesses, with changing live values, exercise the shared-shadow and shared-buffer cases between registers.

// File: rtl/wide_reg_bridge_pkg.sv
package wide_reg_bridge_pkg;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_LIVE,
    RD_SHADOW,
    RD_SP_LO,
    RD_SP_HI
  } rdSel_e;

  typedef struct packed {
    rdSel_e rdSel;
    logic   snap;
    logic   bufWr;
    logic   commit;
    logic   spLoWr;
    logic   spHiWr;
  } bridgeStrobes_t;

endpackage

// File: rtl/wide_reg_bridge_ctrl.sv
module wide_reg_bridge_ctrl
  import wide_reg_bridge_pkg::*;
#(
  parameter int NUM_REGS       = 4,
  parameter int BYTES          = 3,
  parameter int ADDR_W         = 8,
  parameter int INHIBIT_CYCLES = 4,
  localparam int BW    = (BYTES > 1) ? $clog2(BYTES) : 1,
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rdEn,
  input  logic              wrEn,
  output bridgeStrobes_t    st,
  output logic [IDX_W-1:0]  regSel,
  output logic [BW-1:0]     byteSel,
  output logic              intInhibit
);

  localparam int CNT_W = $clog2(INHIBIT_CYCLES + 1);
  localparam logic [ADDR_W-1:0] SP_LO_ADDR = ADDR_W'(NUM_REGS << BW);
  localparam logic [ADDR_W-1:0] SP_HI_ADDR = ADDR_W'((NUM_REGS << BW) + 1);

  logic [ADDR_W-1:0] regField;
  logic [BW-1:0]     byteField;
  logic              regHit;
  logic              topByte;
  logic              lowByte;
  logic              spLoHit;
  logic              spHiHit;
  logic [CNT_W-1:0]  inhCnt;

  assign regField  = addr >> BW;
  assign byteField = addr[BW-1:0];
  assign regHit    = (regField < ADDR_W'(NUM_REGS)) &&
                     ({1'b0, byteField} < (BW+1)'(BYTES));
  assign topByte   = byteField == BW'(BYTES - 1);
  assign lowByte   = byteField == '0;
  assign spLoHit   = addr == SP_LO_ADDR;
  assign spHiHit   = addr == SP_HI_ADDR;
  assign regSel    = regField[IDX_W-1:0];
  assign byteSel   = byteField;

  always_comb begin
    st = '0;
    st.rdSel = RD_NONE;
    if (rdEn) begin
      if (regHit)       st.rdSel = lowByte ? RD_LIVE : RD_SHADOW;
      else if (spLoHit) st.rdSel = RD_SP_LO;
      else if (spHiHit) st.rdSel = RD_SP_HI;
    end
    st.snap   = rdEn && regHit && lowByte;
    st.bufWr  = wrEn && regHit && !topByte;
    st.commit = wrEn && regHit && topByte;
    st.spLoWr = wrEn && spLoHit;
    st.spHiWr = wrEn && spHiHit;
  end

  // Inhibit window: reloaded by every stack-pointer low-byte write.
  always_ff @(posedge clk) begin
    if (!rstN)          inhCnt <= '0;
    else if (st.spLoWr) inhCnt <= CNT_W'(INHIBIT_CYCLES);
    else if (inhCnt != '0) inhCnt <= inhCnt - CNT_W'(1);
  end

  assign intInhibit = inhCnt != '0;

endmodule

// File: rtl/wide_reg_bridge_dp.sv
module wide_reg_bridge_dp
  import wide_reg_bridge_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int BYTES    = 3,
  parameter logic [15:0] SP_RESET = 16'h08FF,
  localparam int BW    = (BYTES > 1) ? $clog2(BYTES) : 1,
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int REG_W = BYTES * 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  bridgeStrobes_t            st,
  input  logic [IDX_W-1:0]          regSel,
  input  logic [BW-1:0]             byteSel,
  input  logic [7:0]                wrData,
  input  logic [NUM_REGS*REG_W-1:0] liveRegs,
  output logic [7:0]                rdData,
  output logic                      updValid,
  output logic [IDX_W-1:0]          updIdx,
  output logic [REG_W-1:0]          updValue,
  output logic [15:0]               spValue
);

  logic [REG_W-1:0] liveArr [NUM_REGS];
  logic [BYTES-2:0][7:0] shadow;   // entry k holds byte k+1
  logic [BYTES-2:0][7:0] holdBuf;  // entry k holds byte k
  logic [REG_W-1:0] liveSel;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_live
    assign liveArr[g] = liveRegs[g*REG_W +: REG_W];
  end

  assign liveSel = liveArr[regSel];

  always_comb begin
    unique case (st.rdSel)
      RD_LIVE:   rdData = liveSel[7:0];
      RD_SHADOW: rdData = shadow[byteSel - BW'(1)];
      RD_SP_LO:  rdData = spValue[7:0];
      RD_SP_HI:  rdData = spValue[15:8];
      default:   rdData = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadow   <= '0;
      holdBuf  <= '0;
      updValid <= 1'b0;
      updIdx   <= '0;
      updValue <= '0;
      spValue  <= SP_RESET;
    end else begin
      if (st.snap) begin
        for (int j = 1; j < BYTES; j++) shadow[j-1] <= liveSel[8*j +: 8];
      end
      if (st.bufWr) holdBuf[byteSel] <= wrData;
      updValid <= st.commit;
      if (st.commit) begin
        updIdx   <= regSel;
        updValue <= {wrData, holdBuf};
      end
      if (st.spLoWr) spValue[7:0]  <= wrData;
      if (st.spHiWr) spValue[15:8] <= wrData;
    end
  end

endmodule

// File: rtl/wide_reg_bridge.sv
module wide_reg_bridge
  import wide_reg_bridge_pkg::*;
#(
  parameter int NUM_REGS       = 4,
  parameter int BYTES          = 3,
  parameter int ADDR_W         = 8,
  parameter int INHIBIT_CYCLES = 4,
  parameter logic [15:0] SP_RESET = 16'h08FF,
  localparam int BW    = (BYTES > 1) ? $clog2(BYTES) : 1,
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int REG_W = BYTES * 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [ADDR_W-1:0]         addr,
  input  logic                      rdEn,
  input  logic                      wrEn,
  input  logic [7:0]                wrData,
  input  logic [NUM_REGS*REG_W-1:0] liveRegs,
  output logic [7:0]                rdData,
  output logic                      updValid,
  output logic [IDX_W-1:0]          updIdx,
  output logic [REG_W-1:0]          updValue,
  output logic [15:0]               spValue,
  output logic                      intInhibit
);

  bridgeStrobes_t   st;
  logic [IDX_W-1:0] regSel;
  logic [BW-1:0]    byteSel;

  wide_reg_bridge_ctrl #(
    .NUM_REGS(NUM_REGS), .BYTES(BYTES), .ADDR_W(ADDR_W),
    .INHIBIT_CYCLES(INHIBIT_CYCLES)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .addr(addr), .rdEn(rdEn), .wrEn(wrEn),
    .st(st), .regSel(regSel), .byteSel(byteSel), .intInhibit(intInhibit)
  );

  wide_reg_bridge_dp #(
    .NUM_REGS(NUM_REGS), .BYTES(BYTES), .SP_RESET(SP_RESET)
  ) dp_i (
    .clk(clk), .rstN(rstN), .st(st), .regSel(regSel), .byteSel(byteSel),
    .wrData(wrData), .liveRegs(liveRegs), .rdData(rdData),
    .updValid(updValid), .updIdx(updIdx), .updValue(updValue),
    .spValue(spValue)
  );

endmodule

// File: rtl/wide_reg_bridge_chk.sv
module wide_reg_bridge_chk #(
  parameter int NUM_REGS       = 4,
  parameter int BYTES          = 3,
  parameter int ADDR_W         = 8,
  parameter int INHIBIT_CYCLES = 4,
  localparam int BW    = (BYTES > 1) ? $clog2(BYTES) : 1,
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int REG_W = BYTES * 8
) (
  input logic                      clk,
  input logic                      rstN,
  input logic [ADDR_W-1:0]         addr,
  input logic                      rdEn,
  input logic                      wrEn,
  input logic [NUM_REGS*REG_W-1:0] liveRegs,
  input logic [7:0]                rdData,
  input logic                      updValid,
  input logic [IDX_W-1:0]          updIdx,
  input logic                      intInhibit
);

  localparam int SP_LO = NUM_REGS << BW;

  int  regNum, byteNum;
  logic mapped, topHit, lowHit, spLoWrite;
  int  inhRun;

  assign regNum    = int'(addr) >> BW;
  assign byteNum   = int'(addr) & ((1 << BW) - 1);
  assign mapped    = (regNum < NUM_REGS) && (byteNum < BYTES);
  assign topHit    = mapped && (byteNum == BYTES - 1);
  assign lowHit    = mapped && (byteNum == 0);
  assign spLoWrite = wrEn && (int'(addr) == SP_LO);

  always_ff @(posedge clk) begin
    if (!rstN)          inhRun <= 0;
    else if (spLoWrite) inhRun <= 0;
    else if (intInhibit) inhRun <= inhRun + 1;
    else                inhRun <= 0;
  end

  a_r1_live_low: assert property (@(posedge clk) disable iff (!rstN)
    rdEn && lowHit |-> rdData == liveRegs[regNum*REG_W +: 8]);

  a_r11_idle_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |-> rdData == 8'h00);

  a_r4_no_early_commit: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && topHit) |=> !updValid);

  a_r5_commit_index: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && topHit |=> updValid && updIdx == $past(addr[BW +: IDX_W]));

  a_r7_inhibit_starts: assert property (@(posedge clk) disable iff (!rstN)
    spLoWrite |=> intInhibit);

  a_r7_inhibit_bounded: assert property (@(posedge clk) disable iff (!rstN)
    intInhibit |-> inhRun < INHIBIT_CYCLES);

  a_r9_no_spurious_inhibit: assert property (@(posedge clk) disable iff (!rstN)
    !intInhibit && !spLoWrite |=> !intInhibit);

endmodule

bind wide_reg_bridge wide_reg_bridge_chk #(
  .NUM_REGS(NUM_REGS), .BYTES(BYTES), .ADDR_W(ADDR_W),
  .INHIBIT_CYCLES(INHIBIT_CYCLES)
) chk_i (
  .clk(clk), .rstN(rstN), .addr(addr), .rdEn(rdEn), .wrEn(wrEn),
  .liveRegs(liveRegs), .rdData(rdData), .updValid(updValid),
  .updIdx(updIdx), .intInhibit(intInhibit)
);

// File: tb/wide_reg_bridge_tb_top.sv
module wide_reg_bridge_tb_top;

  localparam int NR = 4;
  localparam int NB = 3;
  localparam int INH = 4;
  localparam logic [15:0] SPR = 16'h08FF;
  localparam int SPLO = 16;
  localparam int SPHI = 17;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] addr = '0;
  logic rdEn = 1'b0, wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [NR*NB*8-1:0] liveRegs = '0;
  logic [7:0] rdData;
  logic updValid;
  logic [1:0] updIdx;
  logic [NB*8-1:0] updValue;
  logic [15:0] spValue;
  logic intInhibit;

  int nTests = 0, nFail = 0;

  // bench model
  logic [7:0] mShadow [1:NB-1];
  logic [7:0] mBuf [0:NB-2];
  logic [15:0] mSp;
  int mCnt;
  logic mUpdV;
  int mUpdIdx;
  logic [NB*8-1:0] mUpdVal;

  always #10 clk = ~clk;

  wide_reg_bridge dut_i (
    .clk(clk), .rstN(rstN), .addr(addr), .rdEn(rdEn), .wrEn(wrEn),
    .wrData(wrData), .liveRegs(liveRegs), .rdData(rdData),
    .updValid(updValid), .updIdx(updIdx), .updValue(updValue),
    .spValue(spValue), .intInhibit(intInhibit)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] liveByte(input int r, input int b);
    return liveRegs[(r*NB + b)*8 +: 8];
  endfunction

  function automatic logic [7:0] expRead(input logic rd, input int a);
    int r = a >> 2;
    int b = a & 3;
    if (!rd) return 8'h00;
    if (r < NR && b < NB) return (b == 0) ? liveByte(r, 0) : mShadow[b];
    if (a == SPLO) return mSp[7:0];
    if (a == SPHI) return mSp[15:8];
    return 8'h00;
  endfunction

  task automatic modelReset();
    for (int j = 1; j < NB; j++) mShadow[j] = 8'h00;
    for (int j = 0; j < NB - 1; j++) mBuf[j] = 8'h00;
    mSp = SPR; mCnt = 0; mUpdV = 1'b0; mUpdIdx = 0; mUpdVal = '0;
  endtask

  // Called just after a falling edge; ends just after the next falling edge.
  task automatic step(input logic rd, input logic wr, input int a,
                      input logic [7:0] d, input string tag);
    int r = a >> 2;
    int b = a & 3;
    logic mapped = (r < NR) && (b < NB);
    rdEn = rd; wrEn = wr; addr = 8'(a); wrData = d;
    #2;
    chk({tag, " rdData"}, 32'(rdData), 32'(expRead(rd, a)));
    @(posedge clk);
    mUpdV = 1'b0;
    if (rd && mapped && b == 0)
      for (int j = 1; j < NB; j++) mShadow[j] = liveByte(r, j);
    if (wr && mapped) begin
      if (b < NB - 1) mBuf[b] = d;
      else begin
        mUpdV = 1'b1; mUpdIdx = r;
        mUpdVal = {d, mBuf[1], mBuf[0]};
      end
    end
    if (wr && a == SPLO) begin mSp[7:0] = d; mCnt = INH; end
    else if (mCnt > 0) mCnt--;
    if (wr && a == SPHI) mSp[15:8] = d;
    @(negedge clk);
    chk({tag, " updValid"}, 32'(updValid), 32'(mUpdV));
    if (mUpdV) begin
      chk({tag, " updIdx"}, 32'(updIdx), 32'(mUpdIdx));
      chk({tag, " updValue"}, 32'(updValue), 32'(mUpdVal));
    end
    chk({tag, " spValue"}, 32'(spValue), 32'(mSp));
    chk({tag, " intInhibit"}, 32'(intInhibit), 32'(mCnt > 0));
  endtask

  task automatic idle(input string tag);
    step(1'b0, 1'b0, 0, 8'h00, tag);
  endtask

  initial begin
    #(20 * 150000);
    nFail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5A17));
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R10 reset state
    chk("R10 spValue", 32'(spValue), 32'(SPR));
    chk("R10 intInhibit", 32'(intInhibit), 0);
    chk("R10 updValid", 32'(updValid), 0);
    // R3: upper byte without snapshot gives the cleared shadow
    step(1'b1, 1'b0, 6, 8'h00, "R3");
    // R1 / R2: snapshot, then live value changes
    liveRegs[1*NB*8 +: 24] = 24'hA1B2C3;
    step(1'b1, 1'b0, 4, 8'h00, "R1");
    liveRegs[1*NB*8 +: 24] = 24'h112233;
    step(1'b1, 1'b0, 5, 8'h00, "R2");
    step(1'b1, 1'b0, 6, 8'h00, "R2");
    step(1'b1, 1'b0, 9, 8'h00, "R2 shared shadow");
    // R10: commit right after reset uses zero buffer
    step(1'b0, 1'b1, 2, 8'h9C, "R10 buffer");
    // R4 / R5
    step(1'b0, 1'b1, 8, 8'h11, "R4");
    step(1'b0, 1'b1, 9, 8'h22, "R4");
    step(1'b0, 1'b1, 10, 8'h33, "R5");
    idle("R5 pulse end");
    // R6: buffer from register 0 used by register 3
    step(1'b0, 1'b1, 0, 8'h55, "R6");
    step(1'b0, 1'b1, 1, 8'h66, "R6");
    step(1'b0, 1'b1, 14, 8'h77, "R6");
    // R7: inhibit window
    step(1'b0, 1'b1, SPLO, 8'h80, "R7");
    for (int i = 0; i < 5; i++) idle("R7 window");
    // R8: restart
    step(1'b0, 1'b1, SPLO, 8'h40, "R8");
    idle("R8"); idle("R8");
    step(1'b0, 1'b1, SPLO, 8'h41, "R8");
    for (int i = 0; i < 5; i++) idle("R8 window");
    // R9
    step(1'b0, 1'b1, SPHI, 8'h12, "R9");
    idle("R9");
    step(1'b1, 1'b0, SPLO, 8'h00, "R9 read");
    step(1'b1, 1'b0, SPHI, 8'h00, "R9 read");
    // R11 unmapped
    step(1'b1, 1'b0, 3, 8'h00, "R11");
    step(1'b1, 1'b0, 20, 8'h00, "R11");
    step(1'b0, 1'b1, 7, 8'hEE, "R11");
    step(1'b0, 1'b1, 19, 8'hEE, "R11");
    step(1'b0, 1'b1, 6, 8'hDD, "R11 buffer kept");
    // random mix
    for (int i = 0; i < 400; i++) begin
      int a = int'($urandom_range(0, 19));
      logic rd = 1'($urandom);
      logic wr = 1'($urandom_range(0, 2) == 0);
      for (int k = 0; k < NR * NB; k++) liveRegs[k*8 +: 8] = 8'($urandom);
      step(rd, wr, a, 8'($urandom), "R2/R5 random");
    end
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule